// File: doc/BRIEF.md
# Power-State and Watchdog Controller

This block keeps track of the power state of a small peripheral that receives commands, and it forces that peripheral back to sleep when a fixed awake window runs out. A wake-token pulse moves the block from sleep or idle to awake. A simplified serial front end delivers word-address bytes and a Stop pulse. A word address of 0x01 closed by a Stop asks for sleep, and 0x02 closed by a Stop asks for idle. Such a request is honoured only while the block is awake and the command engine is not busy.

While the block is awake, a watchdog counter runs and nothing can clear it. When it reaches the configured interval, the block drops to sleep even if a command or a transfer is still in progress. Sleep and idle differ in what they keep. Entering sleep fires a clear strobe for the command engine, the I/O buffer and the volatile storage, and it zeroes the status byte. Idle holds a retain level, so the volatile contents survive, except a temporary key that was produced by the copy mode of a MAC check. That key is dropped through its own strobe.

The block also holds the one-byte status code returned to the host. It reads 0x11 after a wake, 0xFF after a receive or CRC failure, and 0x0F after an execution failure caused by the current state.

Top module: `pwr_wdog_ctrl`

## Requirements
- R1: `state_o` encodes sleep as 0, awake as 1 and idle as 2. After reset the block is in sleep, `status_o` is 0x00, `wd_count_o` is 0 and every strobe is low.
- R2: A `wake_i` pulse taken in sleep or idle puts the block in awake on the next cycle, with `status_o` equal to 0x11 and `wd_count_o` equal to 0.
- R3: While awake, `wd_count_o` rises by one each cycle, and a `wake_i` pulse does not restart it.
- R4: After exactly WD_CYCLES awake cycles, the block goes to sleep whatever the value of `busy_i`. If the expiry falls in the same cycle as an accepted request, the expiry wins.
- R5: `wd_count_o` is 0 in every cycle spent in sleep or idle.
- R6: A Stop that follows a word-address byte of 0x01, taken while awake and not busy, puts the block in sleep on the next cycle. Every entry to sleep raises `sleep_clear_o` for exactly the first sleep cycle and sets `status_o` to 0x00.
- R7: A Stop that follows a word-address byte of 0x02, taken while awake and not busy, puts the block in idle. `retain_o` is high exactly while in idle, and `status_o` keeps its value across idle.
- R8: On entry to idle, `key_drop_o` is high for the first idle cycle if `key_copy_i` was high, and it stays low otherwise.
- R9: A sleep or idle request made while `busy_i` is high, or while in sleep or idle, leaves the state unchanged.
- R10: A Stop after any other word-address value, or a Stop with no word-address byte before it, leaves the state unchanged.
- R11: While awake, `rx_err_i` sets `status_o` to 0xFF and `exec_err_i` sets it to 0x0F, both on the next cycle. When both are raised together, 0xFF is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Decoded wake-token pulse |
| wa_valid_i | input | 1 | Word-address byte valid |
| wa_byte_i | input | WA_W | Word-address byte |
| stop_i | input | 1 | Stop condition pulse |
| busy_i | input | 1 | Command engine busy |
| rx_err_i | input | 1 | Receive or CRC failure pulse |
| exec_err_i | input | 1 | Execution failure pulse |
| key_copy_i | input | 1 | Temporary key came from copy mode |
| state_o | output | 2 | Power state (0 sleep, 1 awake, 2 idle) |
| wd_count_o | output | CW | Watchdog count |
| sleep_clear_o | output | 1 | Clear strobe for engine, buffer and volatile storage |
| retain_o | output | 1 | Volatile storage retained (idle) |
| key_drop_o | output | 1 | Invalidate the copy-derived temporary key |
| status_o | output | 8 | Status byte for the host |

## Verification
Watchdog expiry and an accepted idle request can fall in the same cycle. The bench provokes this by waiting after a wake until the counter is two short of the interval, then sending the word address 0x02 so that its Stop lands on the last awake cycle, with `key_copy_i` held high. The result is judged correct only if the block lands in sleep with the clear strobe high, no key-drop strobe and the status byte at 0x00. A second pairing, a busy request during the cycles of a running watchdog, is covered by holding `busy_i` across a whole awake window and checking the count on every cycle.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
   typedef enum logic [1:0] {
      PS_SLEEP = 2'd0,
      PS_AWAKE = 2'd1,
      PS_IDLE  = 2'd2
   } pwr_state_e;

   localparam logic [7:0] STAT_CLEAR = 8'h00;
   localparam logic [7:0] STAT_WOKE  = 8'h11;
   localparam logic [7:0] STAT_RETRY = 8'hFF;
   localparam logic [7:0] STAT_EXEC  = 8'h0F;
endpackage

// File: rtl/pwr_wd_counter.sv
module pwr_wd_counter #(
   parameter int WD_CYCLES = 1024,
   localparam int CW = $clog2(WD_CYCLES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active_i,
   input  logic          keep_i,
   output logic          expire_o,
   output logic [CW-1:0] count_o
);
   localparam logic [CW-1:0] LAST = CW'(WD_CYCLES - 1);

   generate
      if (WD_CYCLES < 2) begin : g_bad_interval
         $error("WD_CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (keep_i) cnt_q <= cnt_q + 1'b1;
      else             cnt_q <= '0;
   end

   assign expire_o = active_i && (cnt_q == LAST);
   assign count_o  = cnt_q;

   // R5
   wd_rest_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active_i |-> cnt_q == '0);
   // R4
   wd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/pwr_req_decode.sv
module pwr_req_decode #(
   parameter int               WA_W     = 8,
   parameter logic [WA_W-1:0]  SLEEP_WA = 'h01,
   parameter logic [WA_W-1:0]  IDLE_WA  = 'h02
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush_i,
   input  logic            wa_valid_i,
   input  logic [WA_W-1:0] wa_byte_i,
   input  logic            stop_i,
   output logic            sleep_req_o,
   output logic            idle_req_o
);
   generate
      if (SLEEP_WA == IDLE_WA) begin : g_bad_codes
         $error("sleep and idle word addresses must differ");
      end
   endgenerate

   logic [WA_W-1:0] wa_q;
   logic            have_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wa_q   <= '0;
         have_q <= 1'b0;
      end else if (flush_i || stop_i) begin
         have_q <= 1'b0;
      end else if (wa_valid_i) begin
         wa_q   <= wa_byte_i;
         have_q <= 1'b1;
      end
   end

   assign sleep_req_o = stop_i && have_q && (wa_q == SLEEP_WA);
   assign idle_req_o  = stop_i && have_q && (wa_q == IDLE_WA);
endmodule

// File: rtl/pwr_status.sv
module pwr_status
   import pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       awake_i,
   input  logic       enter_sleep_i,
   input  logic       wake_acc_i,
   input  logic       rx_err_i,
   input  logic       exec_err_i,
   output logic [7:0] status_o
);
   logic [7:0] stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      stat_q <= STAT_CLEAR;
      else if (enter_sleep_i)          stat_q <= STAT_CLEAR;
      else if (wake_acc_i)             stat_q <= STAT_WOKE;
      else if (awake_i && rx_err_i)    stat_q <= STAT_RETRY;
      else if (awake_i && exec_err_i)  stat_q <= STAT_EXEC;
   end

   assign status_o = stat_q;

   // R11
   retry_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (awake_i && rx_err_i && !enter_sleep_i) |=> stat_q == STAT_RETRY);
endmodule

// File: rtl/pwr_wdog_ctrl.sv
module pwr_wdog_ctrl
   import pwr_pkg::*;
#(
   parameter int              WD_CYCLES = 1024,
   parameter int              WA_W      = 8,
   parameter logic [WA_W-1:0] SLEEP_WA  = 'h01,
   parameter logic [WA_W-1:0] IDLE_WA   = 'h02,
   localparam int             CW        = $clog2(WD_CYCLES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wake_i,
   input  logic            wa_valid_i,
   input  logic [WA_W-1:0] wa_byte_i,
   input  logic            stop_i,
   input  logic            busy_i,
   input  logic            rx_err_i,
   input  logic            exec_err_i,
   input  logic            key_copy_i,
   output logic [1:0]      state_o,
   output logic [CW-1:0]   wd_count_o,
   output logic            sleep_clear_o,
   output logic            retain_o,
   output logic            key_drop_o,
   output logic [7:0]      status_o
);
   pwr_state_e st_q, st_nxt;
   logic expire, sleep_req, idle_req;
   logic enter_sleep, enter_idle, wake_acc;
   logic clr_q, kdrop_q;

   pwr_req_decode #(.WA_W(WA_W), .SLEEP_WA(SLEEP_WA), .IDLE_WA(IDLE_WA)) u_dec (
      .clk(clk), .rst_n(rst_n), .flush_i(st_q != PS_AWAKE),
      .wa_valid_i(wa_valid_i), .wa_byte_i(wa_byte_i), .stop_i(stop_i),
      .sleep_req_o(sleep_req), .idle_req_o(idle_req));

   always_comb begin
      st_nxt = st_q;
      unique case (st_q)
         PS_SLEEP, PS_IDLE: if (wake_i) st_nxt = PS_AWAKE;
         PS_AWAKE: begin
            if (expire)                      st_nxt = PS_SLEEP;
            else if (!busy_i && sleep_req)   st_nxt = PS_SLEEP;
            else if (!busy_i && idle_req)    st_nxt = PS_IDLE;
         end
         default: st_nxt = PS_SLEEP;
      endcase
   end

   assign enter_sleep = (st_q == PS_AWAKE) && (st_nxt == PS_SLEEP);
   assign enter_idle  = (st_q == PS_AWAKE) && (st_nxt == PS_IDLE);
   assign wake_acc    = (st_q != PS_AWAKE) && (st_nxt == PS_AWAKE);

   pwr_wd_counter #(.WD_CYCLES(WD_CYCLES)) u_wd (
      .clk(clk), .rst_n(rst_n),
      .active_i(st_q == PS_AWAKE),
      .keep_i((st_q == PS_AWAKE) && (st_nxt == PS_AWAKE)),
      .expire_o(expire), .count_o(wd_count_o));

   pwr_status u_stat (
      .clk(clk), .rst_n(rst_n), .awake_i(st_q == PS_AWAKE),
      .enter_sleep_i(enter_sleep), .wake_acc_i(wake_acc),
      .rx_err_i(rx_err_i), .exec_err_i(exec_err_i), .status_o(status_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= PS_SLEEP;
         clr_q   <= 1'b0;
         kdrop_q <= 1'b0;
      end else begin
         st_q    <= st_nxt;
         clr_q   <= enter_sleep;
         kdrop_q <= enter_idle && key_copy_i;
      end
   end

   assign state_o       = st_q;
   assign sleep_clear_o = clr_q;
   assign retain_o      = (st_q == PS_IDLE);
   assign key_drop_o    = kdrop_q;

   // R4
   expire_to_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (state_o == PS_SLEEP) && sleep_clear_o);
   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == PS_AWAKE && busy_i && !expire) |=> state_o == PS_AWAKE);
   // R2
   wake_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != PS_AWAKE && wake_i) |=> (status_o == STAT_WOKE) && (wd_count_o == '0));
   // R6
   clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_clear_o |=> !sleep_clear_o);
   // R8
   key_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      key_drop_o |-> (state_o == PS_IDLE) && $past(key_copy_i));
endmodule

// File: tb/sim_pwr_wdog_ctrl.sv
`timescale 1ns/100ps
module sim_pwr_wdog_ctrl;
   localparam int WD = 16;
   localparam int CW = $clog2(WD);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wake = 0, wa_valid = 0, stop = 0, busy = 0, rx_err = 0, exec_err = 0, key_copy = 0;
   logic [7:0] wa_byte = 8'h00;
   logic [1:0] state;
   logic [CW-1:0] wd_count;
   logic clr, retain, kdrop;
   logic [7:0] status;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pwr_wdog_ctrl #(.WD_CYCLES(WD)) u0 (
      .clk(clk), .rst_n(rst_n), .wake_i(wake), .wa_valid_i(wa_valid),
      .wa_byte_i(wa_byte), .stop_i(stop), .busy_i(busy), .rx_err_i(rx_err),
      .exec_err_i(exec_err), .key_copy_i(key_copy), .state_o(state),
      .wd_count_o(wd_count), .sleep_clear_o(clr), .retain_o(retain),
      .key_drop_o(kdrop), .status_o(status));

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_wake();
      wake = 1; step(); wake = 0;
   endtask

   task automatic send_req(input logic [7:0] b);
      wa_valid = 1; wa_byte = b; step();
      wa_valid = 0; stop = 1; step(); stop = 0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run hung");
      finish_run();
   end

   initial begin
      repeat (3) step();
      rst_n = 1;
      // R1 reset state
      chk("R1 state", state, 0);
      chk("R1 status", status, 8'h00);
      chk("R1 count", wd_count, 0);
      chk("R1 strobes", {clr, retain, kdrop}, 0);
      step();
      chk("R5 count held in sleep", wd_count, 0);

      // R2 wake
      do_wake();
      chk("R2 state", state, 1);
      chk("R2 status", status, 8'h11);
      chk("R2 count", wd_count, 0);

      // R3 / R4: busy whole window, extra wake mid-window
      busy = 1;
      for (int i = 1; i < WD; i++) begin
         if (i == 5) wake = 1;
         step();
         wake = 0;
         chk("R3 count", wd_count, i);
         chk("R4 awake before expiry", state, 1);
      end
      step();
      chk("R4 expiry to sleep while busy", state, 0);
      chk("R6 clear on expiry", clr, 1);
      chk("R6 status cleared", status, 8'h00);
      busy = 0;
      step();
      chk("R6 clear one cycle", clr, 0);
      chk("R5 count zero in sleep", wd_count, 0);

      // R9 request while asleep ignored
      send_req(8'h02);
      chk("R9 request in sleep", state, 0);

      // R11 status codes
      do_wake();
      rx_err = 1; step(); rx_err = 0;
      chk("R11 rx err", status, 8'hFF);
      exec_err = 1; step(); exec_err = 0;
      chk("R11 exec err", status, 8'h0F);
      rx_err = 1; exec_err = 1; step(); rx_err = 0; exec_err = 0;
      chk("R11 both", status, 8'hFF);

      // R9 busy requests ignored
      busy = 1;
      send_req(8'h01);
      chk("R9 busy sleep req", state, 1);
      send_req(8'h02);
      chk("R9 busy idle req", state, 1);
      busy = 0;

      // R10 stop without word address
      stop = 1; step(); stop = 0;
      chk("R10 bare stop", state, 1);

      // R7 idle keeps status, no key drop
      send_req(8'h02);
      chk("R7 idle", state, 2);
      chk("R7 retain", retain, 1);
      chk("R7 status kept", status, 8'hFF);
      chk("R8 no drop", kdrop, 0);
      chk("R5 count zero idle", wd_count, 0);
      step();
      chk("R7 still idle", state, 2);
      do_wake();
      chk("R2 wake from idle", state, 1);
      chk("R2 status from idle", status, 8'h11);
      chk("R7 retain low awake", retain, 0);

      // R8 copy key dropped on idle
      key_copy = 1;
      send_req(8'h02);
      chk("R8 key drop", kdrop, 1);
      step();
      chk("R8 key drop one cycle", kdrop, 0);
      key_copy = 0;

      // R6 sleep request
      do_wake();
      send_req(8'h01);
      chk("R6 sleep", state, 0);
      chk("R6 clear", clr, 1);
      chk("R6 status", status, 8'h00);
      chk("R7 retain low sleep", retain, 0);

      // R10/R6/R7 sweep of every word address
      for (int v = 0; v < 256; v++) begin
         int exp_st;
         do_wake();
         send_req(v[7:0]);
         exp_st = (v == 1) ? 0 : (v == 2) ? 2 : 1;
         if (v == 1)      chk("R6 sweep", state, exp_st);
         else if (v == 2) chk("R7 sweep", state, exp_st);
         else             chk("R10 sweep", state, exp_st);
         if (state == 1) send_req(8'h01);
      end

      // R4 expiry collides with idle request; expiry wins
      do_wake();
      key_copy = 1;
      repeat (WD - 2) step();
      send_req(8'h02);
      chk("R4 collision state", state, 0);
      chk("R4 collision clear", clr, 1);
      chk("R4 collision no drop", kdrop, 0);
      chk("R4 collision status", status, 8'h00);
      key_copy = 0;

      finish_run();
   end
endmodule